// File: doc/BRIEF.md
# Voltage Code Slew Ramp Controller

This block drives the 6-bit output-voltage code of a step-down converter toward a target code at a programmed slew rate. Two target codes, a "low" and a "high" one, are presented by neighbouring registers. A select input picks between them. The block moves its output code one code at a time, and a busy flag stays high for as long as the code has not reached the target.

The code scale is not linear. The spacing between adjacent codes grows from 25 mV to 50 mV and then to 100 mV as the code rises. A fixed spacing in time between steps would therefore break the requested mV/µs rate. Instead, the block keeps a running budget of slewed voltage, measured in 10 µV units. On each microsecond tick it adds the selected rate to that budget. It takes one step when the budget covers the voltage gap of that particular step, and the remainder is carried into the next step. The highest slew setting skips the ramp and loads the target at once. When the block is disabled, the code simply tracks the selected target.

Top module: `vcode_ramp`

## Requirements
- R1: The target is `code_lo` while `hi_sel`=0 and `code_hi` while `hi_sel`=1.
- R2: When enabled with `slew_sel`≠7, `vcode` changes by at most one code per clock, always toward the target. It never passes the target and holds once it is equal.
- R3: The voltage of a code c is 800+25·c mV for c≤31, 1600+50·(c−32) mV for 32≤c≤60, and 3100+100·(c−61) mV for c≥61. The gap of a step is the voltage difference of its two codes: 25 mV when the lower code is ≤31, 50 mV when it is 32..59, and 100 mV when it is ≥60.
- R4: Each clock with `us_tick`=1 while moving adds the rate (in 10 µV) to a budget. When the budget reaches the step gap, the code steps at that edge and the budget keeps the excess. The budget is cleared while the code equals the target.
- R5: `slew_sel` 0..6 selects 0.11, 0.22, 0.45, 0.9, 1.8, 3.6 and 7.2 mV/µs (11, 22, 45, 90, 180, 360 and 720 units per tick).
- R6: No step is taken on a clock without `us_tick`.
- R7: With `slew_sel`=7, `vcode` equals the target one clock later and `busy` is 0.
- R8: With the block enabled and `slew_sel`≠7, `busy` after each edge is 1 exactly when the new `vcode` differs from the target sampled at that edge. It rises one clock after a differing target appears, and it falls at the edge on which the code arrives.
- R9: Changing `hi_sel` so that a different target is chosen starts a ramp and sets `busy` one clock later.
- R10: A target change during a ramp continues from the current code and keeps the accumulated budget.
- R11: While `rst`=1 or `ramp_en`=0, `vcode` is loaded with the selected target at every clock, `busy` is 0 and the budget is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ramp_en | input | 1 | Ramp enable; when low, the code tracks the target directly |
| hi_sel | input | 1 | Target select: 0 picks `code_lo`, 1 picks `code_hi` |
| code_lo | input | 6 | Low target code |
| code_hi | input | 6 | High target code |
| slew_sel | input | 3 | Slew rate setting; 7 means immediate |
| us_tick | input | 1 | One-clock pulse per microsecond |
| vcode | output | 6 | Current voltage code (registered) |
| busy | output | 1 | Ramp in progress (registered) |

## Verification
Every result appears on the first clock edge after the inputs that cause it. An immediate load, a disabled load and the rise of `busy` therefore show one edge after the stimulus. A ramp step shows on the edge of the tick that fills the budget, and `busy` falls on that same edge. The bench drives inputs on the falling edge. Its reference model updates on each rising edge from the voltage table and the rate list, and it compares `vcode` and `busy` on the next falling edge. Directed checks count edges from the stimulus: 4 then 3 ticks at 7.2 mV/µs for 25 mV steps, 7 for a 50 mV step, 14 for a 100 mV step, 228 at 0.11 mV/µs and 28 at 0.9 mV/µs.

// File: rtl/vcode_ramp_pkg.sv
package vcode_ramp_pkg;
  // budget unit: 10 uV
  localparam int RATE_W      = 10;
  localparam int ACC_W       = 14;
  localparam int FINE_LAST   = 31;    // last lower code of a 25 mV step
  localparam int MID_LAST    = 59;    // last lower code of a 50 mV step
  localparam int GAP_FINE    = 2500;
  localparam int GAP_MID     = 5000;
  localparam int GAP_COARSE  = 10000;

  function automatic logic [RATE_W-1:0] rate_of(input logic [2:0] s);
    case (s)
      3'd0:    rate_of = RATE_W'(11);
      3'd1:    rate_of = RATE_W'(22);
      3'd2:    rate_of = RATE_W'(45);
      3'd3:    rate_of = RATE_W'(90);
      3'd4:    rate_of = RATE_W'(180);
      3'd5:    rate_of = RATE_W'(360);
      default: rate_of = RATE_W'(720);
    endcase
  endfunction
endpackage

// File: rtl/vcode_tgt_sel.sv
module vcode_tgt_sel #(
  parameter int CODE_W = 6
) (
  input  logic              hi_sel,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  output logic [CODE_W-1:0] tgt
);
  // R1
  always_comb tgt = hi_sel ? code_hi : code_lo;
endmodule

// File: rtl/vcode_step_gap.sv
module vcode_step_gap
  import vcode_ramp_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] code,
  input  logic              up,
  output logic [ACC_W-1:0]  gap
);
  localparam logic [CODE_W-1:0] FINE_TOP = CODE_W'(FINE_LAST);
  localparam logic [CODE_W-1:0] MID_TOP  = CODE_W'(MID_LAST);

  logic [CODE_W-1:0] base;

  // the gap of a step is set by the lower code of the pair (R3)
  always_comb begin
    base = up ? code : code - 1'b1;
    if (base <= FINE_TOP)     gap = ACC_W'(GAP_FINE);
    else if (base <= MID_TOP) gap = ACC_W'(GAP_MID);
    else                      gap = ACC_W'(GAP_COARSE);
  end
endmodule

// File: rtl/vcode_pace.sv
module vcode_pace
  import vcode_ramp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate,
  input  logic [ACC_W-1:0]  gap,
  output logic              step
);
  localparam int SUM_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum  = {1'b0, acc_q} + SUM_W'(rate);
    step = tick && !clear && (sum >= {1'b0, gap});
  end

  // R4: budget grows per tick, keeps the excess after a step
  always_ff @(posedge clk) begin
    if (rst || clear)   acc_q <= '0;
    else if (step)      acc_q <= ACC_W'(sum - {1'b0, gap});
    else if (tick)      acc_q <= ACC_W'(sum);
  end

  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q < ACC_W'(GAP_COARSE));
endmodule

// File: rtl/vcode_ramp.sv
module vcode_ramp
  import vcode_ramp_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int SLEW_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ramp_en,
  input  logic              hi_sel,
  input  logic [CODE_W-1:0] code_lo,
  input  logic [CODE_W-1:0] code_hi,
  input  logic [SLEW_W-1:0] slew_sel,
  input  logic              us_tick,
  output logic [CODE_W-1:0] vcode,
  output logic              busy
);
  localparam logic [SLEW_W-1:0] SLEW_IMM = '1;

  logic [CODE_W-1:0] tgt;
  logic [CODE_W-1:0] code_q, code_nx;
  logic              busy_q;
  logic              up, moving, imm, clear, step;
  logic [ACC_W-1:0]  gap;
  logic [RATE_W-1:0] rate;

  vcode_tgt_sel #(.CODE_W(CODE_W)) u_sel (
    .hi_sel (hi_sel),
    .code_lo(code_lo),
    .code_hi(code_hi),
    .tgt    (tgt)
  );

  vcode_step_gap #(.CODE_W(CODE_W)) u_gap (
    .code(code_q),
    .up  (up),
    .gap (gap)
  );

  vcode_pace u_pace (
    .clk  (clk),
    .rst  (rst),
    .clear(clear),
    .tick (us_tick),
    .rate (rate),
    .gap  (gap),
    .step (step)
  );

  always_comb begin
    imm    = (slew_sel == SLEW_IMM);
    up     = (tgt > code_q);
    moving = (code_q != tgt);
    clear  = !ramp_en || imm || !moving;
    rate   = rate_of(3'(slew_sel));
    if (!ramp_en || imm) code_nx = tgt;
    else if (step)       code_nx = up ? code_q + 1'b1 : code_q - 1'b1;
    else                 code_nx = code_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= tgt;
      busy_q <= 1'b0;
    end else begin
      code_q <= code_nx;
      busy_q <= ramp_en && !imm && (code_nx != tgt);
    end
  end

  assign vcode = code_q;
  assign busy  = busy_q;

  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_en && !imm |=> (code_q == $past(code_q)) ||
      (code_q == $past(code_q) + 1'b1) || (code_q == $past(code_q) - 1'b1));

  // R2
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_en && !imm && (code_q < tgt) |=> code_q <= $past(tgt));

  // R6
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_en && !imm && !us_tick |=> code_q == $past(code_q));

  // R7
  imm_jump_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_en && imm |=> (code_q == $past(tgt)) && !busy_q);

  // R11
  off_load_chk: assert property (@(posedge clk) disable iff (rst)
    !ramp_en |=> (code_q == $past(tgt)) && !busy_q);

  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ramp_en && !imm && (code_q == tgt) |=> !busy_q);
endmodule

// File: tb/vcode_ramp_bench.sv
`timescale 1ns/1ps
module vcode_ramp_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ramp_en = 1'b0;
  logic       hi_sel = 1'b0;
  logic [5:0] code_lo = 6'd0;
  logic [5:0] code_hi = 6'd8;
  logic [2:0] slew_sel = 3'd6;
  logic       us_tick = 1'b0;
  logic [5:0] vcode;
  logic       busy;

  int nchk = 0;
  int nbad = 0;
  bit cmp_on = 1'b0;

  int m_code, m_busy, m_acc;
  int rate_tab [7] = '{11, 22, 45, 90, 180, 360, 720};

  always #2 clk = ~clk;

  vcode_ramp u_vcode_ramp (
    .clk(clk), .rst(rst), .ramp_en(ramp_en), .hi_sel(hi_sel),
    .code_lo(code_lo), .code_hi(code_hi), .slew_sel(slew_sel),
    .us_tick(us_tick), .vcode(vcode), .busy(busy)
  );

  // R3 voltage table in mV
  function automatic int volt(input int c);
    if (c <= 31)      return 800 + 25 * c;
    else if (c <= 60) return 1600 + 50 * (c - 32);
    else              return 3100 + 100 * (c - 61);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on every rising edge
  always @(posedge clk) begin
    int t, nxt, d, s;
    t = hi_sel ? int'(code_hi) : int'(code_lo);
    if (rst || !ramp_en || slew_sel == 3'd7) begin
      m_code = t; m_busy = 0; m_acc = 0;
    end else if (m_code == t) begin
      m_acc = 0; m_busy = 0;
    end else begin
      if (us_tick) begin
        nxt = (t > m_code) ? m_code + 1 : m_code - 1;
        d = volt(nxt) - volt(m_code);
        if (d < 0) d = -d;
        d = d * 100;
        s = m_acc + rate_tab[slew_sel];
        if (s >= d) begin m_code = nxt; m_acc = s - d; end
        else m_acc = s;
      end
      m_busy = (m_code != t) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("model code R1 R2 R3 R4 R5 R10", int'(vcode), m_code);
      chk("model busy R8 R9 R11", int'(busy), m_busy);
    end
  end

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1200000;
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    edges(3);
    rst = 1'b0;
    cmp_on = 1'b1;
    edges(1);
    // R11 reset state
    chk("R11 reset code", int'(vcode), 0);
    chk("R11 reset busy", int'(busy), 0);

    // R4 R5 R8: 7.2 mV/us, 25 mV steps need 4 then 3 ticks
    ramp_en = 1'b1; us_tick = 1'b1; code_lo = 6'd2;
    edges(1);
    chk("R8 busy rise", int'(busy), 1);
    edges(2);
    chk("R4 no step yet", int'(vcode), 0);
    edges(1);
    chk("R4 first step", int'(vcode), 1);
    edges(3);
    chk("R4 carried remainder", int'(vcode), 2);
    chk("R8 busy fall", int'(busy), 0);
    edges(2);

    // R6: no tick, no step
    us_tick = 1'b0; code_lo = 6'd5;
    edges(20);
    chk("R6 hold code", int'(vcode), 2);
    chk("R6 busy held", int'(busy), 1);
    us_tick = 1'b1;
    edges(40);
    chk("R2 arrive", int'(vcode), 5);

    // R7 immediate
    slew_sel = 3'd7; code_lo = 6'd60;
    edges(1);
    chk("R7 jump code", int'(vcode), 60);
    chk("R7 busy low", int'(busy), 0);
    edges(2);

    // R3 100 mV steps: 14 ticks up and down
    slew_sel = 3'd6; code_lo = 6'd61;
    edges(13);
    chk("R3 coarse up wait", int'(vcode), 60);
    edges(1);
    chk("R3 coarse up step", int'(vcode), 61);
    edges(2);
    code_lo = 6'd60;
    edges(13);
    chk("R3 coarse down wait", int'(vcode), 61);
    edges(1);
    chk("R3 coarse down step", int'(vcode), 60);

    // R3 50 mV step: 7 ticks
    slew_sel = 3'd7; code_lo = 6'd32; edges(2);
    slew_sel = 3'd6; code_lo = 6'd33;
    edges(6);
    chk("R3 mid wait", int'(vcode), 32);
    edges(1);
    chk("R3 mid step", int'(vcode), 33);

    // R3 31 to 32 is a 25 mV step: 4 ticks
    slew_sel = 3'd7; code_lo = 6'd31; edges(2);
    slew_sel = 3'd6; code_lo = 6'd32;
    edges(3);
    chk("R3 band edge wait", int'(vcode), 31);
    edges(1);
    chk("R3 band edge step", int'(vcode), 32);

    // R5 slowest rate: 228 ticks
    slew_sel = 3'd7; code_lo = 6'd0; edges(2);
    slew_sel = 3'd0; code_lo = 6'd1;
    edges(227);
    chk("R5 0.11 wait", int'(vcode), 0);
    edges(1);
    chk("R5 0.11 step", int'(vcode), 1);

    // R5 0.9 mV/us: 28 ticks
    slew_sel = 3'd7; code_lo = 6'd0; edges(2);
    slew_sel = 3'd3; code_lo = 6'd1;
    edges(27);
    chk("R5 0.9 wait", int'(vcode), 0);
    edges(1);
    chk("R5 0.9 step", int'(vcode), 1);

    // R10 retarget keeps budget
    slew_sel = 3'd7; code_lo = 6'd0; edges(2);
    slew_sel = 3'd6; code_lo = 6'd10;
    edges(5);
    chk("R10 before retarget", int'(vcode), 1);
    code_lo = 6'd0;
    edges(1);
    chk("R10 still moving", int'(vcode), 1);
    chk("R10 busy", int'(busy), 1);
    edges(1);
    chk("R10 back at target", int'(vcode), 0);
    chk("R10 busy done", int'(busy), 0);

    // R9 R1 select toggle
    slew_sel = 3'd7; code_lo = 6'd3; code_hi = 6'd9; edges(2);
    slew_sel = 3'd6; hi_sel = 1'b1;
    edges(1);
    chk("R9 busy on toggle", int'(busy), 1);
    chk("R9 code unchanged", int'(vcode), 3);
    edges(60);
    chk("R1 high target reached", int'(vcode), 9);
    chk("R8 busy after arrival", int'(busy), 0);

    // R11 disabled tracking
    ramp_en = 1'b0; code_hi = 6'd20;
    edges(1);
    chk("R11 disabled load", int'(vcode), 20);
    chk("R11 disabled busy", int'(busy), 0);
    hi_sel = 1'b0;
    edges(1);
    chk("R1 low target when disabled", int'(vcode), 3);
    edges(2);

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule